// File: doc/BRIEF.md
# Multi-Port Banked Scratchpad Memory

This block is an on-chip local memory shared by several parallel load/store ports. The storage is split into a power-of-two number of single-port banks. A compile-time bit mask, `SEL_MASK`, marks which address bit positions choose the bank. The remaining address bits, kept in their original order, give the word inside that bank. The number of banks is two raised to the number of set bits in the mask. The default mask marks the two lowest address bits.

Each port drives a request with a valid flag, a write enable, an address and write data. It gets back a ready flag, a registered read-data bus and a read-response pulse. Ports that address different banks in the same cycle are all served in that cycle. Ports that collide on one bank are arbitrated by that bank's round-robin arbiter. The ports that lose keep their request stable and retry until they see ready.

A saturating counter records how many cycles contained at least one stalled port. It exposes how often bank conflicts cost throughput.

Top module: `banked_scratchpad`

## Requirements
- R1: The bank index is formed from the address bits marked in `SEL_MASK`: the lowest marked position is bank-index bit 0, the next marked position is bit 1, and so on. The unmarked bits, in ascending order, form the word index. There are 2^popcount(`SEL_MASK`) banks. With mask 5'b01010, bank = {addr[3], addr[1]}.
- R2: When every valid port addresses a different bank, every valid port sees `req_ready` high in that same cycle.
- R3: In any cycle, at most one port per bank sees `req_ready` high, and `req_ready` is never high for a port whose `req_valid` is low.
- R4: Each bank arbitrates round-robin. After granting port g, the bank gives priority to ports g+1, g+2, and so on, wrapping around. As a result, k ports colliding on one bank all complete within k cycles, and a port granted in one cycle is not granted in the next while another port requests that bank.
- R5: A request completes in a cycle where `req_valid` and `req_ready` are both high. A completed write stores its data at the addressed word.
- R6: A completed read raises `rsp_valid` for that port only, in the following cycle, with the word on that port's `rsp_rdata` slice. `rsp_valid` is never high without such a read one cycle earlier.
- R7: A read that completes in any cycle after a write to the same address returns the written data, including when the two requests were issued together and the arbiter ordered them.
- R8: `stall_cycles` increments by one after each cycle in which some port has `req_valid` high and `req_ready` low. It never changes otherwise and holds at its all-ones value.
- R9: While `rst_n` is low, and in the first cycle after it rises, `rsp_valid` and `stall_cycles` are zero. With no valid requests, `req_ready` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port request valid |
| req_we | input | NUM_PORTS | Per-port write enable (1 = write, 0 = read) |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port address, port p at [p*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_PORTS*DATA_W | Per-port write data, port p at [p*DATA_W +: DATA_W] |
| req_ready | output | NUM_PORTS | Per-port grant; low on a valid port means stalled |
| rsp_valid | output | NUM_PORTS | One-cycle pulse when read data is present |
| rsp_rdata | output | NUM_PORTS*DATA_W | Per-port read data, port p at [p*DATA_W +: DATA_W] |
| stall_cycles | output | CNT_W | Saturating count of cycles with a stalled port |

## Verification
The hardest situation to reach from the ports is a write and a read to the same bank issued together, followed by a later read of the written word. Whether the read sees old or new data depends on the round-robin pointer history left behind by every earlier conflict. The stimulus runs a fixed sequence of full-conflict, conflict-free and mixed vectors, which walks each bank's pointer through known states. A bench model of the per-bank pointers then predicts every grant, every stall cycle and every returned word cycle by cycle. The counter is narrowed to three bits so that the table's stall cycles drive it into saturation.

// File: rtl/spad_pkg.sv
package spad_pkg;

    // Number of set bits in mask strictly below bit position pos.
    function automatic int unsigned ones_below(input logic [63:0] mask, input int unsigned pos);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if ((i < pos) && mask[i]) n = n + 1;
        end
        return n;
    endfunction

    function automatic int unsigned ones_total(input logic [63:0] mask);
        return ones_below(mask, 64);
    endfunction

endpackage

// File: rtl/spad_addr_map.sv
// Splits an address into bank index and in-bank word index by a bit mask.
module spad_addr_map
    import spad_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 5,
    parameter int unsigned       BANK_BITS = 2,
    parameter logic [ADDR_W-1:0] SEL_MASK  = 3
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic [BANK_BITS-1:0]        bank,
    output logic [ADDR_W-BANK_BITS-1:0] word
);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        localparam int unsigned RANK = ones_below(64'(SEL_MASK), i);
        if (SEL_MASK[i]) begin : g_sel
            assign bank[RANK] = addr[i];
        end else begin : g_word
            assign word[i - RANK] = addr[i];
        end
    end

endmodule

// File: rtl/spad_rr_arb.sv
// Round-robin arbiter for one bank: one grant per cycle among requesting ports.
module spad_rr_arb #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [N-1:0]     last;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic [N-1:0] upper;
    logic [N-1:0] pick;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            upper[i] = req[i] && (PTR_W'(i) >= st_q.ptr);
        end
        pick = (|upper) ? upper : req;
        gnt  = pick & (~pick + N'(1));
        st_d.last = gnt;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) st_d.ptr = (i == N - 1) ? '0 : PTR_W'(i + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R3
    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R3
    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt)); // R2

    for (genvar i = 0; i < N; i++) begin : g_rr_chk
        AST_RR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.last[i] && |(req & ~(N'(1) << i))) |-> !gnt[i]); // R4
    end

endmodule

// File: rtl/spad_bank.sv
// One single-port bank: a write or a registered read per cycle.
module spad_bank #(
    parameter int unsigned WORD_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << WORD_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en && we)  st_d.mem[word] = wdata;
        if (en && !we) st_d.rdata     = st_q.mem[word];
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import spad_pkg::*;
#(
    parameter int unsigned       NUM_PORTS = 4,
    parameter int unsigned       ADDR_W    = 5,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SEL_MASK  = 3,
    parameter int unsigned       CNT_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          req_valid,
    input  logic [NUM_PORTS-1:0]          req_we,
    input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]   req_wdata,
    output logic [NUM_PORTS-1:0]          req_ready,
    output logic [NUM_PORTS-1:0]          rsp_valid,
    output logic [NUM_PORTS*DATA_W-1:0]   rsp_rdata,
    output logic [CNT_W-1:0]              stall_cycles
);

    localparam int unsigned BANK_BITS = ones_total(64'(SEL_MASK));
    localparam int unsigned NUM_BANKS = 1 << BANK_BITS;
    localparam int unsigned WORD_W    = ADDR_W - BANK_BITS;

    typedef struct packed {
        logic [NUM_PORTS-1:0]                rv;
        logic [NUM_PORTS-1:0][BANK_BITS-1:0] rbank;
        logic [CNT_W-1:0]                    cnt;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [BANK_BITS-1:0] p_bank      [NUM_PORTS];
    logic [WORD_W-1:0]    p_word      [NUM_PORTS];
    logic [NUM_PORTS-1:0] gnt_by_bank [NUM_BANKS];
    logic [DATA_W-1:0]    bank_rdata  [NUM_BANKS];
    logic [NUM_PORTS-1:0] rdy;
    logic                 any_stall;

    // Address split per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        spad_addr_map #(
            .ADDR_W    (ADDR_W),
            .BANK_BITS (BANK_BITS),
            .SEL_MASK  (SEL_MASK)
        ) u_map (
            .addr (req_addr[p*ADDR_W +: ADDR_W]),
            .bank (p_bank[p]),
            .word (p_word[p])
        );
        assign rsp_rdata[p*DATA_W +: DATA_W] = bank_rdata[st_q.rbank[p]];
    end

    // Per-bank arbitration and storage
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_PORTS-1:0] breq;
        logic [NUM_PORTS-1:0] bgnt;
        logic                 bwe;
        logic [WORD_W-1:0]    bword;
        logic [DATA_W-1:0]    bwdata;

        always_comb begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                breq[p] = req_valid[p] && (p_bank[p] == BANK_BITS'(b));
            end
        end

        spad_rr_arb #(.N(NUM_PORTS)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (breq),
            .gnt   (bgnt)
        );

        always_comb begin
            bwe    = 1'b0;
            bword  = '0;
            bwdata = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bgnt[p]) begin
                    bwe    = req_we[p];
                    bword  = p_word[p];
                    bwdata = req_wdata[p*DATA_W +: DATA_W];
                end
            end
        end

        spad_bank #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .en    (|bgnt),
            .we    (bwe),
            .word  (bword),
            .wdata (bwdata),
            .rdata (bank_rdata[b])
        );

        assign gnt_by_bank[b] = bgnt;
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            rdy[p] = 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                rdy[p] = rdy[p] | gnt_by_bank[b][p];
            end
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.rv = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_valid[p] && rdy[p] && !req_we[p]) begin
                st_d.rv[p]    = 1'b1;
                st_d.rbank[p] = p_bank[p];
            end
        end
        any_stall = |(req_valid & ~rdy);
        if (any_stall && (st_q.cnt != '1)) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready    = rdy;
    assign rsp_valid    = st_q.rv;
    assign stall_cycles = st_q.cnt;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_ready[p] && !req_we[p]) |=> rsp_valid[p]); // R6
        AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[p] |-> $past(req_valid[p] && req_ready[p] && !req_we[p])); // R6
        AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[p] |-> req_valid[p]); // R3
    end

    AST_CNT_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cycles == '1) |=> (stall_cycles == '1)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cycles != $past(stall_cycles)) |->
            (stall_cycles == $past(stall_cycles) + CNT_W'(1))); // R8

endmodule

// File: tb/tb_banked_scratchpad.sv
`timescale 1ns/1ps
module tb_banked_scratchpad;

    localparam int NP  = 4;
    localparam int AW  = 5;
    localparam int DW  = 32;
    localparam int CW  = 3;
    localparam int CMAX = 7;
    localparam int NV  = 10;

    // Per-port field: {valid, we, addr[4:0]}, port 3 leftmost.
    localparam logic [27:0] VEC [NV] = '{
        {7'b1_1_01010, 7'b1_1_01000, 7'b1_1_00010, 7'b1_1_00000}, // all banks distinct, writes
        {7'b1_0_00000, 7'b1_0_00010, 7'b1_0_01000, 7'b1_0_01010}, // distinct, reads
        {7'b1_1_10000, 7'b1_1_00101, 7'b1_1_00100, 7'b1_1_00001}, // all on bank 0, writes
        {7'b1_0_00001, 7'b1_0_00100, 7'b1_0_00101, 7'b1_0_10000}, // all on bank 0, reads
        {7'b1_0_01000, 7'b1_1_01100, 7'b1_0_00010, 7'b1_1_00011}, // write+read pairs per bank
        {7'b0_0_00000, 7'b1_0_01100, 7'b0_0_00000, 7'b1_0_00011}, // read back those writes
        {7'b1_1_00110, 7'b0_0_00000, 7'b1_1_00110, 7'b0_0_00000}, // two writes, same address
        {7'b1_0_00000, 7'b1_0_10000, 7'b1_0_00001, 7'b1_0_00110}, // three on bank 0
        {7'b0_0_00000, 7'b0_0_00000, 7'b1_0_01100, 7'b1_1_01001}, // write and read bank 2
        {7'b0_0_00000, 7'b0_0_00000, 7'b0_0_00000, 7'b1_0_01001}  // read right after write
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      req_valid = '0;
    logic [NP-1:0]      req_we = '0;
    logic [NP*AW-1:0]   req_addr = '0;
    logic [NP*DW-1:0]   req_wdata = '0;
    logic [NP-1:0]      req_ready;
    logic [NP-1:0]      rsp_valid;
    logic [NP*DW-1:0]   rsp_rdata;
    logic [CW-1:0]      stall_cycles;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem_m  [32];
    int            ptr_m  [4];
    int            cnt_m  = 0;
    logic [NP-1:0] exp_rv = '0;
    logic [DW-1:0] exp_rd [NP];

    always #2 clk = ~clk;

    banked_scratchpad #(
        .NUM_PORTS (NP),
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .SEL_MASK  (5'b01010),
        .CNT_W     (CW)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .stall_cycles (stall_cycles)
    );

    // R1: bank = {addr[3], addr[1]} for mask 5'b01010
    function automatic int bank_of(input logic [4:0] a);
        return int'({a[3], a[1]});
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rsp();
        chk(rsp_valid === exp_rv, "R6 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
        for (int p = 0; p < NP; p++) begin
            if (exp_rv[p])
                chk(rsp_rdata[p*DW +: DW] === exp_rd[p], "R5,R7 rsp_rdata",
                    rsp_rdata[p*DW +: DW], exp_rd[p]);
        end
        chk(stall_cycles === CW'(cnt_m), "R8 stall_cycles", 32'(stall_cycles), 32'(cnt_m));
    endtask

    task automatic one_cycle(input logic [27:0] v, input int vi, inout logic [NP-1:0] pend);
        logic [NP-1:0] g;
        logic [3:0]    bank_done;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            req_valid[p]           = pend[p];
            req_we[p]              = v[7*p+5];
            req_addr[p*AW +: AW]   = v[7*p +: 5];
            req_wdata[p*DW +: DW]  = 32'hC0DE_0000 + 32'(vi * 16 + p);
        end
        #1;
        check_rsp();
        g = '0;
        bank_done = '0;
        for (int b = 0; b < 4; b++) begin
            for (int off = 0; off < NP; off++) begin
                int p;
                p = (ptr_m[b] + off) % NP;
                if (!bank_done[b] && pend[p] && bank_of(v[7*p +: 5]) == b) begin
                    g[p] = 1'b1;
                    bank_done[b] = 1'b1;
                    ptr_m[b] = (p + 1) % NP;
                end
            end
        end
        chk(req_ready === g, "R1,R2,R3,R4 req_ready", 32'(req_ready), 32'(g));
        exp_rv = '0;
        for (int p = 0; p < NP; p++) begin
            if (g[p] && !v[7*p+5]) begin
                exp_rv[p] = 1'b1;
                exp_rd[p] = mem_m[v[7*p +: 5]];
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (g[p] && v[7*p+5]) mem_m[v[7*p +: 5]] = 32'hC0DE_0000 + 32'(vi * 16 + p);
        end
        if ((pend & ~g) != '0 && cnt_m < CMAX) cnt_m++;
        pend = pend & ~g;
    endtask

    task automatic run_vec(input logic [27:0] v, input int vi);
        logic [NP-1:0] pend;
        int per_bank [4];
        int expc;
        int cycles;
        expc = 0;
        for (int b = 0; b < 4; b++) per_bank[b] = 0;
        for (int p = 0; p < NP; p++) begin
            pend[p] = v[7*p+6];
            if (pend[p]) per_bank[bank_of(v[7*p +: 5])]++;
        end
        for (int b = 0; b < 4; b++) if (per_bank[b] > expc) expc = per_bank[b];
        cycles = 0;
        while (pend != '0 && cycles < 20) begin
            one_cycle(v, vi, pend);
            cycles++;
        end
        chk(cycles == expc, "R4 cycles to drain", 32'(cycles), 32'(expc));
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = '0;
        #1;
        check_rsp();
        chk(req_ready === '0, "R3 ready without valid", 32'(req_ready), 32'd0);
        exp_rv = '0;
    endtask

    initial begin
        for (int b = 0; b < 4; b++) ptr_m[b] = 0;
        for (int i = 0; i < 32; i++) mem_m[i] = '0;
        for (int p = 0; p < NP; p++) exp_rd[p] = '0;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === '0, "R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk(stall_cycles === '0, "R9 stall in reset", 32'(stall_cycles), 32'd0);
        chk(req_ready === '0, "R9 ready idle", 32'(req_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === '0, "R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(stall_cycles === '0, "R9 stall after reset", 32'(stall_cycles), 32'd0);

        // Vector table
        for (int vi = 0; vi < NV; vi++) run_vec(VEC[vi], vi);
        idle_cycle();
        idle_cycle();

        // R8: counter saturated by the table's conflicts
        chk(stall_cycles === CW'(CMAX), "R8 saturation", 32'(stall_cycles), 32'(CMAX));

        // R7: directed write then read of a fresh address on another bank
        run_vec({7'b0, 7'b0, 7'b0, 7'b1_1_01110}, 20);
        run_vec({7'b0, 7'b1_0_01110, 7'b0, 7'b0}, 21);
        idle_cycle();
        chk(stall_cycles === CW'(CMAX), "R8 holds at max", 32'(stall_cycles), 32'(CMAX));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule